// File: doc/BRIEF.md
# Dual-Channel UART Feature Control Unit

This block holds the device-wide feature byte of a two-channel UART together with the logic that the byte steers. A host write carries a register address, a channel select and a data byte. Writes to the feature address land in the shared byte. Every other write is turned into a per-channel write strobe. In broadcast mode the strobe goes to both channels, not only the addressed one. Setting the reset bit of the feature byte starts a soft reset of fixed length for the selected channel, or for both channels in broadcast mode. The bit clears itself when the reset ends.

The same byte also picks which modem pins carry hardware flow control. It sets whether a sleeping channel is woken by a low level or by any transition on its serial input. It also sets whether the transmit-empty interrupt waits for the transmit shift register to drain. FIFO levels, trigger thresholds and shift-register idle flags come in from the channel datapaths. The block returns sleep state, write strobes, soft resets, remapped flow-control pins and the transmit-empty interrupt.

Top module: `uart2_featctl`

## Requirements
- R1: While rst_n is low, ctl_rd_data is 0x00 and soft_rst, asleep, txe_irq and chan_we are all zero.
- R2: A write to the feature address stores bits 7 (broadcast), 4 (edge wake), 2 (DTR/DSR flow control) and 0 (wait for shifter). ctl_rd_data returns them in the same positions in the cycle after the write. Bits 6, 5 and 3 always read as 0.
- R3: A write to any other address raises chan_we in the same cycle. With bit 7 clear it raises only the bit of wr_chan. With bit 7 set it raises both bits. A write to the feature address raises no chan_we bit.
- R4: A feature write with data bit 1 set raises soft_rst from the next cycle for exactly 4 cycles. It targets the channel in wr_chan, or both channels if bit 7 was already stored. ctl_rd_data bit 1 reads 1 while any soft_rst is high and 0 afterwards. A soft reset leaves the stored bits 7, 4, 2 and 0 unchanged.
- R5: With bit 2 clear, rts_out follows fc_req, dtr_out follows mdm_dtr and fc_go follows cts_in, per channel.
- R6: With bit 2 set, dtr_out follows fc_req, rts_out follows mdm_rts and fc_go follows dsr_in, per channel.
- R7: An awake channel enters sleep one cycle after all of these hold: sleep_req high, TX level 0, tsr_idle high, rx_fifo_empty high, irq_pending low, and, when bit 4 is clear, the synchronized rx_pin high. A pending interrupt or, in level mode, a low rx_pin keeps it awake.
- R8: With bit 4 clear, a sleeping channel wakes when rx_pin goes low. asleep falls on the third rising edge after the change, after two synchronizer stages.
- R9: With bit 4 set, a channel may sleep with rx_pin held low. It is not woken by a steady level, and it wakes on any rx_pin transition with the same three-edge latency.
- R10: asleep falls one cycle after sleep_req drops, and one cycle after the channel's soft_rst rises.
- R11: With bit 0 clear, txe_irq rises one cycle after the TX level crosses from at-or-above the trigger to below it, or after the level reaches 0.
- R12: With bit 0 set, a crossing below the trigger still raises txe_irq. An empty FIFO raises txe_irq only once tsr_idle is also high.
- R13: txe_irq stays high until a cycle with tx_wr or isr_rd for that channel, and it clears in the cycle after the channel's soft_rst rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Host write strobe |
| wr_chan | input | 1 | Addressed channel |
| wr_addr | input | ADDR_W | Host register address |
| wr_data | input | 8 | Host write data |
| chan_we | output | 2 | Per-channel register write strobe |
| ctl_rd_data | output | 8 | Feature byte readback |
| soft_rst | output | 2 | Per-channel soft reset |
| fc_req | input | 2 | Receiver flow-control request per channel |
| mdm_rts | input | 2 | Modem-register RTS value |
| mdm_dtr | input | 2 | Modem-register DTR value |
| rts_out | output | 2 | RTS pin drive |
| dtr_out | output | 2 | DTR pin drive |
| cts_in | input | 2 | CTS pin |
| dsr_in | input | 2 | DSR pin |
| fc_go | output | 2 | Transmit permission to the channel |
| rx_pin | input | 2 | Serial input line, idle high, asynchronous |
| sleep_req | input | 2 | Sleep enabled by host |
| rx_fifo_empty | input | 2 | RX FIFO empty |
| tsr_idle | input | 2 | Transmit shift register idle |
| irq_pending | input | 2 | Another interrupt pending |
| asleep | output | 2 | Channel in sleep |
| tx_lvl | input | 2 x LVL_W | TX FIFO level |
| tx_trig | input | 2 x LVL_W | TX trigger threshold |
| tx_wr | input | 2 | Host TX FIFO write |
| isr_rd | input | 2 | Host interrupt status read |
| txe_irq | output | 2 | Transmit-empty interrupt |

## Verification
A vector table drives distinct patterns on the request, modem-register and pin inputs of the two channels, in both flow-control modes. Each bit has its own value in every row, so a crossed channel or swapped pin shows up. Directed sequences target the other behaviours. Unicast and broadcast writes separate per-channel steering from broadcast. Soft resets are sent to a single channel and to both channels, and each pulse's length is counted. Sleep is tried with the RX line held low and with it toggled in each wake mode, which separates level wake from edge wake. The transmit-empty interrupt is raised by a trigger crossing and by draining to empty, with the shifter busy and then idle, which separates the two interrupt modes.

// File: rtl/uart2fc_pkg.sv
package uart2fc_pkg;

  localparam int NCH       = 2;
  localparam int B_BCAST   = 7;
  localparam int B_RXEDGE  = 4;
  localparam int B_DTRFC   = 2;
  localparam int B_SRST    = 1;
  localparam int B_TSRWAIT = 0;

  typedef struct packed {
    logic bcast;
    logic rx_edge;
    logic dtr_fc;
    logic tsr_wait;
  } fc_cfg_t;

  function automatic fc_cfg_t cfg_from_byte(logic [7:0] d);
    fc_cfg_t c;
    c.bcast    = d[B_BCAST];
    c.rx_edge  = d[B_RXEDGE];
    c.dtr_fc   = d[B_DTRFC];
    c.tsr_wait = d[B_TSRWAIT];
    return c;
  endfunction

  function automatic logic [7:0] cfg_readback(fc_cfg_t c, logic busy);
    logic [7:0] r;
    r = 8'h00;
    r[B_BCAST]   = c.bcast;
    r[B_RXEDGE]  = c.rx_edge;
    r[B_DTRFC]   = c.dtr_fc;
    r[B_SRST]    = busy;
    r[B_TSRWAIT] = c.tsr_wait;
    return r;
  endfunction

endpackage

// File: rtl/fc_ctl_reg.sv
module fc_ctl_reg
  import uart2fc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTL_ADDR = '1,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_chan,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output fc_cfg_t           cfg,
  output logic [NCH-1:0]    chan_we,
  output logic [NCH-1:0]    soft_rst,
  output logic [NCH-1:0]    rst_trig,
  output logic [7:0]        rd_data
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic ctl_sel;
  logic ctl_hit;

  assign ctl_sel = (wr_addr == CTL_ADDR);
  assign ctl_hit = wr_en && ctl_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg <= '0;
    else if (ctl_hit) cfg <= cfg_from_byte(wr_data);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic             targeted;

    assign targeted     = cfg.bcast || (wr_chan == 1'(ch));
    assign chan_we[ch]  = wr_en && !ctl_sel && targeted;
    assign rst_trig[ch] = ctl_hit && wr_data[B_SRST] && targeted;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (rst_trig[ch]) cnt <= CNT_W'(RST_CYCLES);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign soft_rst[ch] = (cnt != '0);
  end

  assign rd_data = cfg_readback(cfg, |soft_rst);
endmodule

// File: rtl/fc_sleep_ch.sv
module fc_sleep_ch (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic edge_mode,
  input  logic sleep_req,
  input  logic idle,
  input  logic soft_rst,
  output logic asleep,
  output logic enter_evt,
  output logic wake_evt
);
  logic rx_m, rx_s, rx_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_d <= 1'b1;
    end else begin
      rx_m <= rx_pin;
      rx_s <= rx_m;
      rx_d <= rx_s;
    end
  end

  function automatic logic rx_wake(logic edge_m, logic now, logic prev);
    return edge_m ? (now ^ prev) : !now;
  endfunction

  assign enter_evt = !asleep && sleep_req && idle && (edge_mode || rx_s);
  assign wake_evt  = asleep && (!sleep_req || rx_wake(edge_mode, rx_s, rx_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         asleep <= 1'b0;
    else if (soft_rst)  asleep <= 1'b0;
    else if (wake_evt)  asleep <= 1'b0;
    else if (enter_evt) asleep <= 1'b1;
  end
endmodule

// File: rtl/fc_txe_ch.sv
module fc_txe_ch #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] trig,
  input  logic             tsr_idle,
  input  logic             tsr_wait,
  input  logic             tx_wr,
  input  logic             isr_rd,
  input  logic             soft_rst,
  output logic             irq,
  output logic             set_evt
);
  function automatic logic below_trig(logic [LVL_W-1:0] l, logic [LVL_W-1:0] t);
    return l < t;
  endfunction

  function automatic logic empty_ready(logic [LVL_W-1:0] l, logic idle, logic wait_sh);
    return (l == '0) && (idle || !wait_sh);
  endfunction

  logic below_now, empty_now, below_q, empty_q;

  assign below_now = below_trig(lvl, trig);
  assign empty_now = empty_ready(lvl, tsr_idle, tsr_wait);
  assign set_evt   = (below_now && !below_q) || (empty_now && !empty_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      below_q <= 1'b1;
      empty_q <= 1'b1;
    end else begin
      below_q <= below_now;
      empty_q <= empty_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               irq <= 1'b0;
    else if (soft_rst)        irq <= 1'b0;
    else if (set_evt)         irq <= 1'b1;
    else if (tx_wr || isr_rd) irq <= 1'b0;
  end
endmodule

// File: rtl/uart2_featctl.sv
module uart2_featctl
  import uart2fc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 4'hF,
  parameter int RST_CYCLES = 4,
  parameter int LVL_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_chan,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [7:0]                 wr_data,
  output logic [1:0]                 chan_we,
  output logic [7:0]                 ctl_rd_data,
  output logic [1:0]                 soft_rst,
  input  logic [1:0]                 fc_req,
  input  logic [1:0]                 mdm_rts,
  input  logic [1:0]                 mdm_dtr,
  output logic [1:0]                 rts_out,
  output logic [1:0]                 dtr_out,
  input  logic [1:0]                 cts_in,
  input  logic [1:0]                 dsr_in,
  output logic [1:0]                 fc_go,
  input  logic [1:0]                 rx_pin,
  input  logic [1:0]                 sleep_req,
  input  logic [1:0]                 rx_fifo_empty,
  input  logic [1:0]                 tsr_idle,
  input  logic [1:0]                 irq_pending,
  output logic [1:0]                 asleep,
  input  logic [1:0][LVL_W-1:0]      tx_lvl,
  input  logic [1:0][LVL_W-1:0]      tx_trig,
  input  logic [1:0]                 tx_wr,
  input  logic [1:0]                 isr_rd,
  output logic [1:0]                 txe_irq
);
  fc_cfg_t        cfg;
  logic [NCH-1:0] rst_trig;
  logic [NCH-1:0] sleep_enter;
  logic [NCH-1:0] sleep_wake;
  logic [NCH-1:0] txe_set;
  logic [NCH-1:0] ch_idle;

  fc_ctl_reg #(
    .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .RST_CYCLES(RST_CYCLES)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg), .chan_we(chan_we),
    .soft_rst(soft_rst), .rst_trig(rst_trig), .rd_data(ctl_rd_data)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_comb begin
      if (cfg.dtr_fc) begin
        dtr_out[ch] = fc_req[ch];
        rts_out[ch] = mdm_rts[ch];
        fc_go[ch]   = dsr_in[ch];
      end else begin
        rts_out[ch] = fc_req[ch];
        dtr_out[ch] = mdm_dtr[ch];
        fc_go[ch]   = cts_in[ch];
      end
    end

    assign ch_idle[ch] = (tx_lvl[ch] == '0) && tsr_idle[ch] &&
                         rx_fifo_empty[ch] && !irq_pending[ch];

    fc_sleep_ch u_sleep (
      .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin[ch]), .edge_mode(cfg.rx_edge),
      .sleep_req(sleep_req[ch]), .idle(ch_idle[ch]), .soft_rst(soft_rst[ch]),
      .asleep(asleep[ch]), .enter_evt(sleep_enter[ch]), .wake_evt(sleep_wake[ch])
    );

    fc_txe_ch #(.LVL_W(LVL_W)) u_txe (
      .clk(clk), .rst_n(rst_n), .lvl(tx_lvl[ch]), .trig(tx_trig[ch]),
      .tsr_idle(tsr_idle[ch]), .tsr_wait(cfg.tsr_wait), .tx_wr(tx_wr[ch]),
      .isr_rd(isr_rd[ch]), .soft_rst(soft_rst[ch]), .irq(txe_irq[ch]),
      .set_evt(txe_set[ch])
    );
  end
endmodule

// File: rtl/uart2_featctl_chk.sv
module uart2_featctl_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 4'hF,
  parameter int LVL_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [7:0]            wr_data,
  input logic [1:0]            chan_we,
  input logic [7:0]            ctl_rd_data,
  input logic [1:0]            soft_rst,
  input logic [1:0]            fc_req,
  input logic [1:0]            rts_out,
  input logic [1:0]            dtr_out,
  input logic [1:0]            cts_in,
  input logic [1:0]            dsr_in,
  input logic [1:0]            fc_go,
  input logic [1:0]            sleep_req,
  input logic [1:0]            rx_fifo_empty,
  input logic [1:0]            tsr_idle,
  input logic [1:0]            irq_pending,
  input logic [1:0]            asleep,
  input logic [1:0][LVL_W-1:0] tx_lvl,
  input logic [1:0]            tx_wr,
  input logic [1:0]            isr_rd,
  input logic [1:0]            txe_irq,
  input logic [1:0]            txe_set
);
  p_unicast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctl_rd_data[7]) |-> $onehot0(chan_we));

  for (genvar ch = 0; ch < 2; ch++) begin : g_chk
    p_we_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chan_we[ch] |-> (wr_en && wr_addr != CTL_ADDR));

    p_srst_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_rst[ch]) |-> $past(wr_en && wr_addr == CTL_ADDR && wr_data[1]));

    p_rts_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rd_data[2] |-> (rts_out[ch] == fc_req[ch] && fc_go[ch] == cts_in[ch]));

    p_dtr_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd_data[2] |-> (dtr_out[ch] == fc_req[ch] && fc_go[ch] == dsr_in[ch]));

    p_sleep_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep[ch]) |-> $past(sleep_req[ch] && tx_lvl[ch] == '0 && tsr_idle[ch] &&
                                  rx_fifo_empty[ch] && !irq_pending[ch]));

    p_sleep_srst_r10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst[ch] |=> !asleep[ch]);

    p_txe_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (txe_set[ch] && !soft_rst[ch]) |=> txe_irq[ch]);

    p_txe_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(txe_irq[ch]) |-> $past(tx_wr[ch] || isr_rd[ch] || soft_rst[ch]));
  end
endmodule

bind uart2_featctl uart2_featctl_chk #(
  .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .chan_we(chan_we), .ctl_rd_data(ctl_rd_data), .soft_rst(soft_rst),
  .fc_req(fc_req), .rts_out(rts_out), .dtr_out(dtr_out), .cts_in(cts_in),
  .dsr_in(dsr_in), .fc_go(fc_go), .sleep_req(sleep_req),
  .rx_fifo_empty(rx_fifo_empty), .tsr_idle(tsr_idle), .irq_pending(irq_pending),
  .asleep(asleep), .tx_lvl(tx_lvl), .tx_wr(tx_wr), .isr_rd(isr_rd),
  .txe_irq(txe_irq), .txe_set(txe_set)
);

// File: tb/sim_uart2_featctl.sv
module sim_uart2_featctl;
  localparam logic [3:0] CTL = 4'hF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_chan = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] chan_we, soft_rst, rts_out, dtr_out, fc_go, asleep, txe_irq;
  logic [7:0] ctl_rd_data;
  logic [1:0] fc_req = '0, mdm_rts = '0, mdm_dtr = '0, cts_in = '0, dsr_in = '0;
  logic [1:0] rx_pin = 2'b11, sleep_req = '0, rx_fifo_empty = 2'b11;
  logic [1:0] tsr_idle = 2'b11, irq_pending = '0, tx_wr = '0, isr_rd = '0;
  logic [1:0][7:0] tx_lvl = '0, tx_trig = '0;

  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  uart2_featctl u0 (.*);

  // mode, fc_req, mdm_rts, mdm_dtr, cts_in, dsr_in | exp rts, dtr, go
  typedef struct packed {
    logic m; logic [1:0] fc, mr, md, cts, dsr, e_rts, e_dtr, e_go;
  } fvec_t;
  localparam fvec_t VEC [6] = '{
    '{1'b0, 2'b01, 2'b10, 2'b11, 2'b10, 2'b01, 2'b01, 2'b11, 2'b10},
    '{1'b0, 2'b10, 2'b00, 2'b01, 2'b01, 2'b11, 2'b10, 2'b01, 2'b01},
    '{1'b1, 2'b01, 2'b10, 2'b11, 2'b10, 2'b01, 2'b10, 2'b01, 2'b01},
    '{1'b1, 2'b10, 2'b01, 2'b00, 2'b11, 2'b10, 2'b01, 2'b10, 2'b10},
    '{1'b1, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 2'b11},
    '{1'b0, 2'b00, 2'b11, 2'b10, 2'b11, 2'b00, 2'b00, 2'b10, 2'b11}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic ch, input logic [7:0] d);
    wr_en = 1'b1; wr_chan = ch; wr_addr = CTL; wr_data = d;
    #1 chk("R3 ctl write strobe", 32'(chan_we), 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_write(input logic ch, input logic [1:0] exp_we, input string tag);
    wr_en = 1'b1; wr_chan = ch; wr_addr = 4'h3; wr_data = 8'h5A;
    #1 chk(tag, 32'(chan_we), 32'(exp_we));
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finish_run();
  end

  initial begin
    int n;
    cyc(2);
    // R1 reset state
    chk("R1 rd", 32'(ctl_rd_data), 32'h0);
    chk("R1 srst/asleep/irq/we", 32'({soft_rst, asleep, txe_irq, chan_we}), 32'h0);
    rst_n = 1'b1;
    cyc(1);

    // R2 readback, reserved bits
    ctl_write(1'b0, 8'h79);
    chk("R2 reserved masked", 32'(ctl_rd_data), 32'h11);
    ctl_write(1'b0, 8'h00);
    chk("R2 cleared", 32'(ctl_rd_data), 32'h00);

    // R3 steering
    reg_write(1'b0, 2'b01, "R3 unicast ch0");
    reg_write(1'b1, 2'b10, "R3 unicast ch1");
    ctl_write(1'b0, 8'h80);
    reg_write(1'b0, 2'b11, "R3 broadcast");
    ctl_write(1'b0, 8'h00);

    // R4 soft reset, single channel
    ctl_write(1'b1, 8'h02);
    chk("R4 target ch1", 32'(soft_rst), 32'h2);
    chk("R4 busy bit", 32'(ctl_rd_data), 32'h02);
    n = 0;
    while (soft_rst[1] && n < 10) begin n++; cyc(1); end
    chk("R4 length", 32'(n), 32'd4);
    chk("R4 self clear", 32'(ctl_rd_data), 32'h00);
    // R4 broadcast reset keeps stored bits
    ctl_write(1'b0, 8'h95);
    ctl_write(1'b0, 8'h97);
    chk("R4 both channels", 32'(soft_rst), 32'h3);
    chk("R4 busy with cfg", 32'(ctl_rd_data), 32'h97);
    cyc(5);
    chk("R4 cfg kept", 32'(ctl_rd_data), 32'h95);
    ctl_write(1'b0, 8'h00);

    // R5/R6 flow control table
    foreach (VEC[i]) begin
      ctl_write(1'b0, {5'b0, VEC[i].m, 2'b0});
      fc_req = VEC[i].fc; mdm_rts = VEC[i].mr; mdm_dtr = VEC[i].md;
      cts_in = VEC[i].cts; dsr_in = VEC[i].dsr;
      #1;
      if (VEC[i].m) chk("R6 remap", 32'({rts_out, dtr_out, fc_go}),
                        32'({VEC[i].e_rts, VEC[i].e_dtr, VEC[i].e_go}));
      else          chk("R5 remap", 32'({rts_out, dtr_out, fc_go}),
                        32'({VEC[i].e_rts, VEC[i].e_dtr, VEC[i].e_go}));
      cyc(1);
    end
    ctl_write(1'b0, 8'h00);

    // R7 entry blocked by pending interrupt, then entry
    irq_pending[0] = 1'b1; sleep_req[0] = 1'b1;
    cyc(3);
    chk("R7 pending blocks", 32'(asleep[0]), 32'h0);
    irq_pending[0] = 1'b0;
    cyc(1);
    chk("R7 enter", 32'(asleep[0]), 32'h1);
    // R8 level wake after sync
    rx_pin[0] = 1'b0;
    cyc(2);
    chk("R8 sync latency", 32'(asleep[0]), 32'h1);
    cyc(1);
    chk("R8 level wake", 32'(asleep[0]), 32'h0);
    cyc(3);
    chk("R7 low rx blocks", 32'(asleep[0]), 32'h0);

    // R9 edge mode
    ctl_write(1'b0, 8'h10);
    cyc(1);
    chk("R9 sleep with rx low", 32'(asleep[0]), 32'h1);
    cyc(4);
    chk("R9 level ignored", 32'(asleep[0]), 32'h1);
    rx_pin[0] = 1'b1; rx_fifo_empty[0] = 1'b0;
    cyc(2);
    chk("R9 sync latency", 32'(asleep[0]), 32'h1);
    cyc(1);
    chk("R9 rising wake", 32'(asleep[0]), 32'h0);
    rx_fifo_empty[0] = 1'b1;
    cyc(1);
    chk("R7 re-enter", 32'(asleep[0]), 32'h1);
    rx_pin[0] = 1'b0; rx_fifo_empty[0] = 1'b0;
    cyc(3);
    chk("R9 falling wake", 32'(asleep[0]), 32'h0);
    rx_fifo_empty[0] = 1'b1;
    cyc(1);

    // R10 sleep_req drop and soft reset
    sleep_req[0] = 1'b0;
    cyc(1);
    chk("R10 req drop", 32'(asleep[0]), 32'h0);
    sleep_req[0] = 1'b1;
    cyc(1);
    chk("R10 re-enter", 32'(asleep[0]), 32'h1);
    ctl_write(1'b0, 8'h12);
    cyc(1);
    chk("R10 soft reset wakes", 32'(asleep[0]), 32'h0);
    sleep_req[0] = 1'b0;
    ctl_write(1'b0, 8'h00);
    cyc(6);

    // R11 mode0 on channel 1
    tx_trig[1] = 8'd4; tx_lvl[1] = 8'd6;
    cyc(2);
    chk("R11 above trigger", 32'(txe_irq[1]), 32'h0);
    tx_lvl[1] = 8'd3;
    cyc(1);
    chk("R11 below trigger", 32'(txe_irq[1]), 32'h1);
    cyc(3);
    chk("R13 held", 32'(txe_irq[1]), 32'h1);
    tx_wr[1] = 1'b1;
    cyc(1);
    tx_wr[1] = 1'b0;
    chk("R13 cleared by tx write", 32'(txe_irq[1]), 32'h0);
    tx_trig[1] = 8'd0; tx_lvl[1] = 8'd1;
    cyc(2);
    chk("R11 no event", 32'(txe_irq[1]), 32'h0);
    tx_lvl[1] = 8'd0; tsr_idle[1] = 1'b0;
    cyc(1);
    chk("R11 empty", 32'(txe_irq[1]), 32'h1);
    isr_rd[1] = 1'b1;
    cyc(1);
    isr_rd[1] = 1'b0;
    chk("R13 cleared by status read", 32'(txe_irq[1]), 32'h0);

    // R12 mode1
    ctl_write(1'b0, 8'h01);
    tx_lvl[1] = 8'd1;
    cyc(2);
    tx_lvl[1] = 8'd0;
    cyc(3);
    chk("R12 waits for shifter", 32'(txe_irq[1]), 32'h0);
    tsr_idle[1] = 1'b1;
    cyc(1);
    chk("R12 shifter idle", 32'(txe_irq[1]), 32'h1);
    isr_rd[1] = 1'b1;
    cyc(1);
    isr_rd[1] = 1'b0;
    tsr_idle[1] = 1'b0; tx_trig[1] = 8'd4; tx_lvl[1] = 8'd6;
    cyc(2);
    chk("R12 cleared", 32'(txe_irq[1]), 32'h0);
    tx_lvl[1] = 8'd2;
    cyc(1);
    chk("R12 trigger crossing", 32'(txe_irq[1]), 32'h1);

    // R13 soft reset clears
    ctl_write(1'b1, 8'h03);
    cyc(1);
    chk("R13 soft reset clears", 32'(txe_irq[1]), 32'h0);
    cyc(5);

    finish_run();
  end
endmodule